// File: doc/BRIEF.md
# Lock-Bit Register Mutex

This block is a single 32-bit register that several processors use to agree on who may drive a shared peripheral. The top bit is a lock flag. The lower 31 bits carry the identifier of the processor that took the lock. A processor that wants ownership writes the lock flag together with its own identifier. It then reads the register back. If the readback matches the word it wrote, it holds the lock. Any other result means a different processor got there first.

Writes that would replace the owner are ignored while the lock flag is set. Writing the all-zero word releases the lock. A release clears only the flag, so the identifier of the last owner stays readable for debugging. The register contents are always visible on the read port, and a separate status output carries the lock flag for other logic.

Top module: `lock_mutex`

## Requirements
- R1: After reset, the read port shows all zeros and the locked output is low.
- R2: While unlocked, a write whose bit 31 is 1 is accepted whole. From the next cycle the read port equals the written word and locked is high.
- R3: While locked, any write of a nonzero word leaves the register unchanged. This includes a word with bit 31 set and a different identifier, so a competing requester reads back a value that differs from what it wrote.
- R4: A write of the all-zero word clears bit 31 on the next cycle and leaves bits 30..0 holding their previous value. This applies whether or not the register was locked.
- R5: While unlocked, a write of a nonzero word with bit 31 clear leaves the register unchanged.
- R6: The locked output always equals bit 31 of the read port.
- R7: In a cycle with the write enable low, the register keeps its value whatever is on the write data input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| wr_en | input | 1 | Write strobe, one write per cycle in which it is high |
| wr_data | input | 32 | Word to write: bit 31 is the lock request, bits 30..0 the requester identifier |
| rd_data | output | 32 | Current register contents: bit 31 is the lock flag, bits 30..0 the owner identifier |
| locked | output | 1 | High while the lock flag is set |

## Verification
The bench builds the block with its default 32-bit word and a two-stage reset synchroniser. At that width it can drive the extreme identifiers: zero with the lock bit set, and the all-ones word, which has the lock bit set and a full identifier. It can also aim competing requests at an owned lock, and it can send the all-zero release both to a locked register and to one that is already free. A random phase then mixes takes, rejected takes, plain nonzero writes, releases and idle cycles with arbitrary data on the write input. Each cycle's readback is compared against a behavioural model of the lock.

// File: rtl/mutex_pkg.sv
package mutex_pkg;

  // Classification of one cycle on the write port
  typedef enum logic [1:0] {
    WK_NONE    = 2'd0,
    WK_TAKE    = 2'd1,
    WK_RELEASE = 2'd2,
    WK_IGNORE  = 2'd3
  } wr_kind_e;

endpackage

// File: rtl/mutex_rst_sync.sv
module mutex_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      assign chain_d = 1'b1;
    end else begin : g_multi
      assign chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/mutex_wr_decode.sv
module mutex_wr_decode
  import mutex_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              lock_q,
  output wr_kind_e          kind
);

  localparam int LOCK_POS = DATA_W - 1;

  always_comb begin
    if (!wr_en) begin
      kind = WK_NONE;
    end else if (wr_data == '0) begin
      kind = WK_RELEASE;
    end else if (!lock_q && wr_data[LOCK_POS]) begin
      kind = WK_TAKE;
    end else begin
      kind = WK_IGNORE;
    end
  end

endmodule

// File: rtl/mutex_lock_reg.sv
module mutex_lock_reg
  import mutex_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wr_kind_e          kind,
  input  logic [DATA_W-2:0] wr_id,
  output logic              lock_q,
  output logic [DATA_W-2:0] id_q
);

  localparam int ID_W = DATA_W - 1;

  logic            lock_d;
  logic [ID_W-1:0] id_d;
  logic            upd_en;

  // Next-state process
  always_comb begin
    upd_en = 1'b0;
    lock_d = lock_q;
    id_d   = id_q;
    unique case (kind)
      WK_TAKE: begin
        upd_en = 1'b1;
        lock_d = 1'b1;
        id_d   = wr_id;
      end
      WK_RELEASE: begin
        upd_en = 1'b1;
        lock_d = 1'b0;
      end
      default: begin
        upd_en = 1'b0;
      end
    endcase
  end

  // Register process with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      id_q   <= '0;
    end else if (upd_en) begin
      lock_q <= lock_d;
      id_q   <= id_d;
    end
  end

endmodule

// File: rtl/lock_mutex.sv
module lock_mutex
  import mutex_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              locked
);

  localparam int ID_W = DATA_W - 1;

  logic            rst_sync_n;
  wr_kind_e        kind;
  logic            lock_q;
  logic [ID_W-1:0] id_q;

  mutex_rst_sync #(
    .STAGES(SYNC_STAGES)
  ) i_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  mutex_wr_decode #(
    .DATA_W(DATA_W)
  ) i_wr_decode (
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .lock_q (lock_q),
    .kind   (kind)
  );

  mutex_lock_reg #(
    .DATA_W(DATA_W)
  ) i_lock_reg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .kind  (kind),
    .wr_id (wr_data[ID_W-1:0]),
    .lock_q(lock_q),
    .id_q  (id_q)
  );

  assign rd_data = {lock_q, id_q};
  assign locked  = lock_q;

endmodule

// File: rtl/lock_mutex_chk.sv
module lock_mutex_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              locked
);

  localparam int LOCK_POS = DATA_W - 1;

  AST_LOCKED_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
    locked == rd_data[LOCK_POS]); // R6

  AST_TAKE_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && wr_en && wr_data[LOCK_POS]) |=> (locked && rd_data == $past(wr_data))); // R2

  AST_HOLD_WHEN_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && wr_en && wr_data != '0) |=> $stable(rd_data)); // R3

  AST_RELEASE_KEEPS_ID: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == '0) |=> (!locked && rd_data[LOCK_POS-1:0] == $past(rd_data[LOCK_POS-1:0]))); // R4

  AST_PLAIN_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && wr_en && !wr_data[LOCK_POS] && wr_data != '0) |=> $stable(rd_data)); // R5

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(rd_data)); // R7

endmodule

bind lock_mutex lock_mutex_chk #(
  .DATA_W(DATA_W)
) i_lock_mutex_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .wr_en  (wr_en),
  .wr_data(wr_data),
  .rd_data(rd_data),
  .locked (locked)
);

// File: tb/test_lock_mutex.sv
module test_lock_mutex;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        locked;

  int total;
  int bad;
  bit checking;
  bit finished;

  // Behavioural reference
  logic [31:0] mdl;
  string       tag;

  lock_mutex i_lock_mutex (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .rd_data(rd_data),
    .locked (locked)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Reference model: follows the requirements, one update per rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      mdl = 32'h0;
      tag = "R1";
    end else if (!wr_en) begin
      tag = "R7";
    end else if (wr_data == 32'h0) begin
      mdl[31] = 1'b0;
      tag = "R4";
    end else if (mdl[31]) begin
      tag = "R3";
    end else if (wr_data[31]) begin
      mdl = wr_data;
      tag = "R2";
    end else begin
      tag = "R5";
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    if (checking) begin
      total++;
      if (rd_data !== mdl) begin
        bad++;
        $display("FAIL %s: rd_data actual=%h expected=%h", tag, rd_data, mdl);
      end
      total++;
      if (locked !== rd_data[31] || locked !== mdl[31]) begin
        bad++;
        $display("FAIL R6: locked actual=%b expected=%b", locked, mdl[31]);
      end
    end
  end

  task automatic drive(input logic en, input logic [31:0] d);
    @(posedge clk);
    #1;
    wr_en   = en;
    wr_data = d;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, $urandom);
  endtask

  // Watchdog
  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total    = 0;
    bad      = 0;
    checking = 1'b0;
    finished = 1'b0;
    wr_en    = 1'b0;
    wr_data  = 32'h0;
    rst_n    = 1'b1;
    #2 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    checking = 1'b1;       // R1: reset state is checked from here on
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(5);

    drive(1'b1, 32'h0000_1234);  // R5 plain write while free
    drive(1'b1, 32'h8000_0005);  // R2 take, ID 5
    drive(1'b1, 32'h8000_0009);  // R3 rival take
    drive(1'b1, 32'h0000_0077);  // R3 plain write while owned
    drive(1'b0, 32'h0000_0000);  // R7 zero on data, no strobe
    drive(1'b1, 32'h0000_0000);  // R4 release, ID 5 kept
    drive(1'b1, 32'h8000_0009);  // R2 take, ID 9
    drive(1'b1, 32'h0000_0000);  // R4 release
    drive(1'b1, 32'h0000_0000);  // R4 release while free
    drive(1'b1, 32'h8000_0000);  // R2 take with ID 0
    drive(1'b1, 32'hFFFF_FFFF);  // R3 all ones while owned
    drive(1'b1, 32'h0000_0000);  // R4 release
    drive(1'b1, 32'hFFFF_FFFF);  // R2 take with all-ones ID
    drive(1'b0, 32'hFFFF_FFFF);  // R7
    drive(1'b1, 32'h7FFF_FFFF);  // R3
    drive(1'b1, 32'h0000_0000);  // R4
    drive(1'b1, 32'h7FFF_FFFF);  // R5 largest plain word while free
    idle(2);

    for (int i = 0; i < 400; i++) begin
      int sel;
      sel = $urandom_range(0, 4);
      case (sel)
        0: drive(1'b1, 32'h8000_0000 | ($urandom & 32'h7FFF_FFFF));
        1: drive(1'b1, 32'h0);
        2: drive(1'b1, $urandom & 32'h7FFF_FFFF);
        3: drive(1'b0, $urandom);
        default: drive(1'b1, $urandom);
      endcase
    end
    idle(3);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule